// File: doc/BRIEF.md
# Serial Three-Bit Combination Lock

This controller opens a lock from a key that arrives one bit at a time. The user sets a single key switch and presses ENTER once for each bit. After the third press the controller compares the collected bits against a secret combination and gives a verdict: either the unlock output or the error output goes high.

The combination comes in on a three-bit input bus. It is captured into a register while the lock reset is held, so later changes on that bus have no effect on the current attempt. A mismatch on any bit is remembered but not reported straight away. The error output stays low until all three bits are in, so an observer cannot tell from the outputs which bit was wrong. The ENTER input is a level signal, and only its low-to-high transition counts as a press. The verdict holds until the next reset.

Top module: `combo_lock`

## Requirements
- R1: While `rst` is high at a clock edge, both `unlock_o` and `error_o` are low after that edge, and the next press is treated as the first key bit.
- R2: `code_i` is captured on every clock edge where `rst` is high. Changes on `code_i` while `rst` is low do not affect the verdict.
- R3: A press is a low-to-high transition of `enter_i` seen at a clock edge. Holding `enter_i` high over several cycles counts as exactly one press.
- R4: Key bits are compared in order. The first press after reset is checked against `code_i[0]`, the second against `code_i[1]` and the third against `code_i[2]`, using the value of `key_i` at the press edge.
- R5: After fewer than three presses since reset, both `unlock_o` and `error_o` are low, even if a bit already mismatched.
- R6: After the third press, `unlock_o` goes high in the cycle following that press edge if all three bits matched.
- R7: After the third press, `error_o` goes high in the cycle following that press edge if any of the three bits mismatched.
- R8: Once a verdict is shown, it stays unchanged and further presses have no effect until `rst` is asserted.
- R9: `unlock_o` and `error_o` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high lock reset; also captures the combination |
| enter_i | input | 1 | ENTER button level; a rising transition is one press |
| key_i | input | 1 | Key-bit switch value |
| code_i | input | 3 | Combination; bit 0 is checked first |
| unlock_o | output | 1 | High when the full key matched |
| error_o | output | 1 | High when the full key had any mismatch |

## Verification
The assertions check, on every cycle, that the two verdict outputs are mutually exclusive, that reset clears them, that a shown verdict holds until reset, and that no verdict appears before three presses have been counted since reset. Which verdict appears for a given key, the order in which bits are compared, and the fact that the combination register ignores bus changes can only be shown by the bench's scenarios. This includes a table of matching and mismatching keys, a held ENTER, presses after the verdict, and a reset in the middle of an entry.

// File: rtl/combo_lock.sv
module combo_lock #(
  parameter int NBITS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter_i,
  input  logic             key_i,
  input  logic [NBITS-1:0] code_i,
  output logic             unlock_o,
  output logic             error_o
);
  localparam int IW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [IW-1:0] LAST = IW'(NBITS - 1);

  logic [NBITS-1:0] code_q;
  logic [IW-1:0]    idx_q;
  logic             enter_q;
  logic             miss_q;
  logic             done_q;

  wire press = enter_i & ~enter_q & ~done_q;
  wire bad   = key_i ^ code_q[idx_q];

  always_ff @(posedge clk) begin
    enter_q <= enter_i;
    if (rst) begin
      code_q <= code_i;
      idx_q  <= '0;
      miss_q <= 1'b0;
      done_q <= 1'b0;
    end else if (press) begin
      miss_q <= miss_q | bad;
      if (idx_q == LAST) done_q <= 1'b1;
      else               idx_q  <= idx_q + 1'b1;
    end
  end

  assign unlock_o = done_q & ~miss_q;
  assign error_o  = done_q &  miss_q;
endmodule

// File: rtl/combo_lock_chk.sv
module combo_lock_chk #(
  parameter int NBITS = 3
) (
  input logic clk,
  input logic rst,
  input logic enter_i,
  input logic unlock_o,
  input logic error_o
);
  localparam int CW = $clog2(NBITS + 1);

  logic          prev_en;
  logic [CW-1:0] seen;

  always_ff @(posedge clk) begin
    prev_en <= enter_i;
    if (rst) seen <= '0;
    else if (enter_i && !prev_en && seen != CW'(NBITS)) seen <= seen + 1'b1;
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) !(unlock_o && error_o)); // R9
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!unlock_o && !error_o)); // R1
  AST_UNLOCK_HOLDS: assert property (@(posedge clk) disable iff (rst) unlock_o |=> unlock_o); // R8
  AST_ERROR_HOLDS: assert property (@(posedge clk) disable iff (rst) error_o |=> error_o); // R8
  AST_NO_EARLY_VERDICT: assert property (@(posedge clk) disable iff (rst)
    (unlock_o || error_o) |-> (seen == CW'(NBITS))); // R5
endmodule

bind combo_lock combo_lock_chk #(.NBITS(NBITS)) u_chk (
  .clk(clk), .rst(rst), .enter_i(enter_i), .unlock_o(unlock_o), .error_o(error_o)
);

// File: tb/tb_combo_lock.sv
`timescale 1ns/1ps
module tb_combo_lock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enter_i = 1'b0;
  logic       key_i = 1'b0;
  logic [2:0] code_i = 3'b000;
  logic       unlock_o, error_o;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  combo_lock dut (.*);

  // {code[2:0], keys[2:0] (bit 0 entered first), expected unlock}
  localparam logic [6:0] VEC [8] = '{
    {3'b101, 3'b101, 1'b1},
    {3'b101, 3'b100, 1'b0},
    {3'b001, 3'b001, 1'b1},
    {3'b001, 3'b100, 1'b0},
    {3'b110, 3'b110, 1'b1},
    {3'b110, 3'b010, 1'b0},
    {3'b000, 3'b000, 1'b1},
    {3'b111, 3'b011, 1'b0}
  };

  task automatic check(input string req, input logic u, input logic e);
    checks++;
    if (unlock_o !== u || error_o !== e) begin
      errors++;
      $display("FAIL %s: unlock/error = %b%b expected %b%b", req, unlock_o, error_o, u, e);
    end
  endtask

  task automatic do_reset(input logic [2:0] c);
    @(negedge clk); rst = 1'b1; code_i = c; enter_i = 1'b0;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic press(input logic b);
    key_i = b; enter_i = 1'b1;
    @(negedge clk); enter_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset(3'b101);
    check("R1 reset state", 1'b0, 1'b0);

    // R4 R5 R6 R7: table walk
    for (int i = 0; i < 8; i++) begin
      logic [2:0] c, k;
      logic ex;
      {c, k, ex} = VEC[i];
      do_reset(c);
      press(k[0]); check("R5 after 1 press", 1'b0, 1'b0);
      press(k[1]); check("R5 after 2 presses", 1'b0, 1'b0);
      press(k[2]);
      check(ex ? "R6 match R4" : "R7 mismatch R4", ex, ~ex);
    end

    // R2: code bus changes after reset are ignored
    do_reset(3'b010);
    code_i = 3'b101;
    press(1'b0); press(1'b1); press(1'b0);
    check("R2 captured code", 1'b1, 1'b0);

    // R3: held ENTER counts once
    do_reset(3'b000);
    key_i = 1'b0; enter_i = 1'b1;
    repeat (5) @(negedge clk);
    enter_i = 1'b0; @(negedge clk);
    press(1'b0);
    check("R3 held enter one press", 1'b0, 1'b0);
    press(1'b0);
    check("R3 third press verdict", 1'b1, 1'b0);

    // R8: presses after unlock are ignored
    press(1'b1); press(1'b1); press(1'b1);
    check("R8 unlock held", 1'b1, 1'b0);

    // R8: presses after error are ignored
    do_reset(3'b111);
    press(1'b0); press(1'b1); press(1'b1);
    check("R7 first-bit miss", 1'b0, 1'b1);
    press(1'b1); press(1'b1); press(1'b1);
    check("R8 error held", 1'b0, 1'b1);

    // R1: reset mid-entry restarts at first bit
    do_reset(3'b110);
    press(1'b1); press(1'b1);
    do_reset(3'b110);
    check("R1 reset clears", 1'b0, 1'b0);
    press(1'b0); press(1'b1);
    check("R1 restart no verdict", 1'b0, 1'b0);
    press(1'b1);
    check("R1 restart unlock", 1'b1, 1'b0);

    // R1: reset after verdict clears it
    do_reset(3'b000);
    check("R1 verdict cleared", 1'b0, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule